// File: doc/BRIEF.md
# Dual-Port Semaphore Flag Bank

A bank of hardware semaphore flags shared by two independent ports, a left port (prefix `a_`) and a right port (prefix `b_`). Each port has a select, a flag index, a write strobe, one data bit and one status bit. A write with data bit 0 raises that port's request for the indexed flag. A write with data bit 1 drops the request, and if the port owns the flag, it also releases it. The status bit tells the reading port whether it currently owns the indexed flag.

Each flag keeps one request bit per port and one owner. A flag that one port has been granted stays with that port until that same port releases it. A request from the other port stays pending in the meantime, and the flag moves to the waiting port on the clock edge of the release. If both ports ask for a free flag on the same edge, the left port wins and the right port's request is held as pending. Software uses the flags to guard shared resources, such as regions of a shared memory. The bank itself is separate from any memory array.

Top module: `sem_flag_bank`

## Requirements
- R1: After reset every flag is free, no request is pending, and a status read of any flag on either port returns 1.
- R2: A write with data bit 0 to a free flag makes the writing port its owner at the next clock edge, and a status read of that flag by that port then returns 0.
- R3: A request for a flag that the other port owns is not granted: the requester reads status 1, and the owner still reads status 0.
- R4: A release write (data bit 1) by a port that does not own the flag leaves ownership unchanged.
- R5: When the owner releases a flag that the other port has a pending request for, the flag is granted to the waiting port at that same clock edge.
- R6: If both ports request the same free flag on the same edge, the left port is granted the flag and the right port's request stays pending.
- R7: An owner's release with no pending request leaves the flag free, and releasing every flag from both ports leaves all flags free.
- R8: The status output is 1 whenever the port's select is low. With select high, the status is 0 only if that port owns the indexed flag. Status is combinational on the index and does not need a clock edge.
- R9: A release write by a non-owner cancels that port's own pending request, so a later release by the owner leaves the flag free.
- R10: Flags are independent: a write affects only the flag at the written index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_sel | input | 1 | Left port semaphore select |
| a_idx | input | IW | Left port flag index |
| a_wr | input | 1 | Left port write strobe |
| a_din | input | 1 | Left port data: 0 request, 1 release |
| a_stat | output | 1 | Left port status: 0 when the left port owns the indexed flag |
| b_sel | input | 1 | Right port semaphore select |
| b_idx | input | IW | Right port flag index |
| b_wr | input | 1 | Right port write strobe |
| b_din | input | 1 | Right port data: 0 request, 1 release |
| b_stat | output | 1 | Right port status: 0 when the right port owns the indexed flag |

## Verification
The bench builds the bank with its default of eight flags and a 3-bit index. This lets it reach the top index and test that every flag stays independent across the whole bank. The directed steps cover grant, refused request, hand-off on release, the same-edge tie and cancellation of a pending request. Random traffic then concentrates both ports on a few flags so that contention and hand-off happen often. The bench checks every flag's status on both ports after each edge.

// File: rtl/sem_flag_bank.sv
module sem_flag_bank #(
  parameter int NFLAGS = 8,
  localparam int IW = (NFLAGS > 1) ? $clog2(NFLAGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_sel,
  input  logic [IW-1:0] a_idx,
  input  logic          a_wr,
  input  logic          a_din,
  output logic          a_stat,
  input  logic          b_sel,
  input  logic [IW-1:0] b_idx,
  input  logic          b_wr,
  input  logic          b_din,
  output logic          b_stat
);

  logic [NFLAGS-1:0] req_a, req_b, own_a, own_b;
  logic [NFLAGS-1:0] nreq_a, nreq_b, nown_a, nown_b;
  logic [NFLAGS-1:0] wa, wb;

  always_comb begin
    for (int i = 0; i < NFLAGS; i++) begin
      wa[i] = a_sel && a_wr && (a_idx == IW'(i));
      wb[i] = b_sel && b_wr && (b_idx == IW'(i));
      nreq_a[i] = wa[i] ? ~a_din : req_a[i];
      nreq_b[i] = wb[i] ? ~b_din : req_b[i];
      nown_a[i] = 1'b0;
      nown_b[i] = 1'b0;
      if (own_a[i] && nreq_a[i])      nown_a[i] = 1'b1;
      else if (own_b[i] && nreq_b[i]) nown_b[i] = 1'b1;
      else if (nreq_a[i])             nown_a[i] = 1'b1;
      else if (nreq_b[i])             nown_b[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_a <= '0;
      req_b <= '0;
      own_a <= '0;
      own_b <= '0;
    end else begin
      req_a <= nreq_a;
      req_b <= nreq_b;
      own_a <= nown_a;
      own_b <= nown_b;
    end
  end

  assign a_stat = ~(a_sel & own_a[a_idx]);
  assign b_stat = ~(b_sel & own_b[b_idx]);

  for (genvar i = 0; i < NFLAGS; i++) begin : g_chk
    a_r3_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
      !(own_a[i] && own_b[i]));
    a_r2_grant_free: assert property (@(posedge clk) disable iff (!rst_n)
      (a_sel && a_wr && !a_din && a_idx == IW'(i) && !own_b[i]) |=> own_a[i]);
    a_r4_keep_left: assert property (@(posedge clk) disable iff (!rst_n)
      (own_a[i] && !(a_sel && a_wr && a_din && a_idx == IW'(i))) |=> own_a[i]);
    a_r4_keep_right: assert property (@(posedge clk) disable iff (!rst_n)
      (own_b[i] && !(b_sel && b_wr && b_din && b_idx == IW'(i))) |=> own_b[i]);
    a_r5_handoff: assert property (@(posedge clk) disable iff (!rst_n)
      (own_a[i] && req_b[i] && a_sel && a_wr && a_din && a_idx == IW'(i) &&
       !(b_sel && b_wr && b_idx == IW'(i))) |=> own_b[i]);
    a_r6_left_first: assert property (@(posedge clk) disable iff (!rst_n)
      (!own_a[i] && !own_b[i] && a_sel && a_wr && !a_din && a_idx == IW'(i) &&
       b_sel && b_wr && !b_din && b_idx == IW'(i)) |=> (own_a[i] && req_b[i]));
  end

endmodule

// File: tb/tb_sem_flag_bank.sv
module tb_sem_flag_bank;
  localparam int N = 8;
  localparam int IW = 3;
  localparam time TCLK = 40;

  logic clk = 0, rst_n = 0;
  logic a_sel = 0, a_wr = 0, a_din = 0, b_sel = 0, b_wr = 0, b_din = 0;
  logic [IW-1:0] a_idx = '0, b_idx = '0;
  logic a_stat, b_stat;

  int nchk = 0, nbad = 0;
  logic [N-1:0] m_ra, m_rb, m_oa, m_ob;

  sem_flag_bank #(.NFLAGS(N)) dut (
    .clk(clk), .rst_n(rst_n),
    .a_sel(a_sel), .a_idx(a_idx), .a_wr(a_wr), .a_din(a_din), .a_stat(a_stat),
    .b_sel(b_sel), .b_idx(b_idx), .b_wr(b_wr), .b_din(b_din), .b_stat(b_stat));

  always #(TCLK/2) clk = ~clk;

  task automatic chk(string tag, string port, int k, logic got, logic exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s port %s flag %0d: got %b expected %b", tag, port, k, got, exp);
    end
  endtask

  function automatic logic [1:0] owner_after(logic oa, logic ob, logic ra, logic rb);
    // a request holds the flag for its owner; otherwise the left request wins
    if (oa && ra) return 2'b01;
    if (ob && rb) return 2'b10;
    if (ra) return 2'b01;
    if (rb) return 2'b10;
    return 2'b00;
  endfunction

  task automatic model_write(logic as, logic [IW-1:0] ai, logic aw, logic ad,
                             logic bs, logic [IW-1:0] bi, logic bw, logic bd);
    logic [1:0] o;
    if (as && aw) m_ra[ai] = ~ad;
    if (bs && bw) m_rb[bi] = ~bd;
    for (int k = 0; k < N; k++) begin
      o = owner_after(m_oa[k], m_ob[k], m_ra[k], m_rb[k]);
      m_oa[k] = o[0];
      m_ob[k] = o[1];
    end
  endtask

  task automatic sweep(string tag);
    a_wr = 0; b_wr = 0; a_sel = 0; b_sel = 0;
    #1;
    chk({tag, "/R8"}, "a", -1, a_stat, 1'b1);
    chk({tag, "/R8"}, "b", -1, b_stat, 1'b1);
    a_sel = 1; b_sel = 1;
    for (int k = 0; k < N; k++) begin
      a_idx = IW'(k); b_idx = IW'(k);
      #1;
      chk(tag, "a", k, a_stat, ~m_oa[k]);
      chk(tag, "b", k, b_stat, ~m_ob[k]);
    end
    a_sel = 0; b_sel = 0;
  endtask

  task automatic cyc(string tag, logic as, logic [IW-1:0] ai, logic ad,
                     logic bs, logic [IW-1:0] bi, logic bd);
    @(negedge clk);
    a_sel = as; a_idx = ai; a_wr = as; a_din = ad;
    b_sel = bs; b_idx = bi; b_wr = bs; b_din = bd;
    @(posedge clk);
    model_write(as, ai, as, ad, bs, bi, bs, bd);
    #1;
    sweep(tag);
  endtask

  initial begin
    #(TCLK * 190000);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    m_ra = '0; m_rb = '0; m_oa = '0; m_ob = '0;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    sweep("R1");

    cyc("R2", 1, 3'd3, 0, 0, 3'd0, 0);
    cyc("R3", 0, 3'd0, 0, 1, 3'd3, 0);
    cyc("R4", 0, 3'd0, 0, 1, 3'd3, 1);
    cyc("R9", 1, 3'd3, 1, 0, 3'd0, 0);
    cyc("R2", 0, 3'd0, 0, 1, 3'd7, 0);
    cyc("R3", 1, 3'd7, 0, 0, 3'd0, 0);
    cyc("R4", 1, 3'd7, 1, 0, 3'd0, 0);
    cyc("R3", 1, 3'd7, 0, 0, 3'd0, 0);
    cyc("R5", 0, 3'd0, 0, 1, 3'd7, 1);
    cyc("R5", 1, 3'd5, 0, 0, 3'd0, 0);
    cyc("R3", 0, 3'd0, 0, 1, 3'd5, 0);
    cyc("R5", 1, 3'd5, 1, 0, 3'd0, 0);
    cyc("R6", 1, 3'd6, 0, 1, 3'd6, 0);
    cyc("R6", 1, 3'd6, 1, 0, 3'd0, 0);
    cyc("R10", 1, 3'd0, 0, 1, 3'd1, 0);
    for (int k = 0; k < N; k++) cyc("R7", 1, IW'(k), 1, 1, IW'(N-1-k), 1);
    for (int k = 0; k < N; k++) cyc("R7", 1, IW'(k), 1, 1, IW'(k), 1);

    for (int n = 0; n < 400; n++) begin
      logic as, bs, ad, bd;
      logic [IW-1:0] ai, bi;
      as = ($urandom % 3) != 0; bs = ($urandom % 3) != 0;
      ai = (n % 50 < 25) ? IW'($urandom % 2) : IW'($urandom % N);
      bi = (n % 50 < 25) ? IW'($urandom % 2) : IW'($urandom % N);
      ad = $urandom % 2; bd = $urandom % 2;
      cyc("R10", as, ai, ad, bs, bi, bd);
    end

    for (int k = 0; k < N; k++) cyc("R7", 1, IW'(k), 1, 1, IW'(k), 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end
endmodule